// File: doc/BRIEF.md
# FPGA Byte-Port Configuration Sender

This block loads a downstream FPGA through a byte-wide write port and three handshake pins. A start pulse makes it hold the target in reset (clear output low) for a fixed number of cycles. It then waits for the target's ready pin to show that erase has finished, and streams a framed bitstream as one-cycle write strobes. The data bytes come from a valid/ready source, and a last flag marks the final byte. The controller adds all fixed framing itself. It sends an eight-byte lead-in. Each frame has a sync byte, 21 payload bytes, a check byte and five extended-write bytes. A four-byte startup tail ends the load.

Between frames the controller looks at the target pins again. It stops framing early if the ready pin drops or the target already reports configuration done. When the load ends it raises either a success flag or an error flag. Both target pins pass through synchronizers before the control logic uses them. A programmable limit bounds the wait for the target to become ready.

Top module: `fpga_cfg_sender`

## Requirements
- R1: After reset, tgt_reset_no is high, and wr_o, src_ready_o, busy_o, ok_o and err_o are all low.
- R2: A start_i pulse while idle clears ok_o and err_o and raises busy_o. It drives tgt_reset_no low for exactly PROG_LOW_CYC cycles and then releases it high.
- R3: No write strobe is issued before tgt_busy_ni has been seen high after the release. If it stays low for more than timeout_i cycles of waiting, the load ends with err_o high and no write at all.
- R4: The load starts with the bytes FF FF FF 4F 80 AF 9B 4B, in that order.
- R5: Each frame is 28 writes: 4F, 21 source bytes in arrival order, 4B, then FF 4B FF FF FF.
- R6: Each strobe on wr_o lasts one cycle, and at least GAP_CYC idle cycles separate two strobes.
- R7: A new frame starts only if, at the frame boundary, tgt_busy_ni is high, tgt_done_i is low and the byte flagged last has not yet been accepted. Otherwise the controller goes straight to the startup tail.
- R8: After the last frame the controller writes exactly four FF bytes.
- R9: At the end, ok_o is set if the last-flagged byte was accepted and tgt_done_i is high. Otherwise err_o is set. busy_o falls, and the flags hold until the next start.
- R10: While the source withholds data inside a frame, the frame waits with no strobe. No byte is lost or repeated.
- R11: Payload slots that follow the last-flagged byte inside its frame are filled with FF without taking from the source.
- R12: start_i has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (pulse, used when idle) |
| timeout_i | input | TMO_W | Longest wait, in cycles, for the target to become ready |
| src_data_i | input | 8 | Bitstream byte from the source |
| src_valid_i | input | 1 | Source byte valid |
| src_last_i | input | 1 | Source byte is the final one |
| src_ready_o | output | 1 | Controller takes the source byte this cycle |
| tgt_reset_no | output | 1 | Target clear, active low |
| tgt_busy_ni | input | 1 | Target ready pin; low means erasing or error |
| tgt_done_i | input | 1 | Target reports configuration done |
| wr_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Byte written with the strobe |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load failed |

## Verification
wr_o and wr_data_o are registered, so a byte appears one cycle after the edge where the source handshake completes. The next strobe comes GAP_CYC+1 cycles later at the earliest. The target pins reach the control logic SYNC_STAGES cycles late. For this reason the bench moves the target pins relative to the observed write count, not to a fixed cycle. It records every strobe into a capture buffer at the clock edge, then compares the whole stream with a sequence built from the requirements. Flags and busy_o are sampled on falling edges, after busy_o has dropped. The clear-pulse width is counted in cycles at each rising edge.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int DATA_N  = 21;
  localparam int HEAD_N  = 8;
  localparam int TAIL_N  = 4;
  localparam int FRAME_N = DATA_N + 7;
  localparam int IDX_W   = $clog2(FRAME_N);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_WAIT, ST_HEAD, ST_CHECK, ST_FRAME, ST_TAIL, ST_EVAL
  } st_e;

  function automatic logic [7:0] fixed_byte(st_e st, logic [IDX_W-1:0] idx);
    logic [7:0] b;
    b = 8'hFF;
    if (st == ST_HEAD) begin
      case (int'(idx))
        3: b = 8'h4F;
        4: b = 8'h80;
        5: b = 8'hAF;
        6: b = 8'h9B;
        7: b = 8'h4B;
        default: b = 8'hFF;
      endcase
    end else if (st == ST_FRAME) begin
      if (int'(idx) == 0) b = 8'h4F;
      else if (int'(idx) == DATA_N + 1 || int'(idx) == DATA_N + 3) b = 8'h4B;
    end
    return b;
  endfunction
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= RST_VAL;
    else         q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= RST_VAL;
      else         q[g] <= q[g-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/fcs_pacer.sv
module fcs_pacer #(
  parameter int GAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic open_o
);
  if (GAP_CYC == 0) begin : g_nogap
    assign open_o = 1'b1;
  end else begin : g_gap
    localparam int CW = $clog2(GAP_CYC + 1);
    logic [CW-1:0] cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt <= '0;
      else if (fire_i)        cnt <= CW'(GAP_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
    assign open_o = (cnt == '0);
  end
endmodule

// File: rtl/fcs_byte_sel.sv
module fcs_byte_sel
  import fcs_pkg::*;
(
  input  st_e              st_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             use_src_i,
  input  logic             data_slot_i,
  input  logic [7:0]       src_data_i,
  output logic [7:0]       byte_o
);
  always_comb begin
    if (use_src_i)        byte_o = src_data_i;
    else if (data_slot_i) byte_o = 8'hFF;  // pad after last
    else                  byte_o = fixed_byte(st_i, idx_i);
  end
endmodule

// File: rtl/fpga_cfg_sender.sv
module fpga_cfg_sender
  import fcs_pkg::*;
#(
  parameter int PROG_LOW_CYC = 8,
  parameter int GAP_CYC      = 2,
  parameter int TMO_W        = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_valid_i,
  input  logic             src_last_i,
  output logic             src_ready_o,
  output logic             tgt_reset_no,
  input  logic             tgt_busy_ni,
  input  logic             tgt_done_i,
  output logic             wr_o,
  output logic [7:0]       wr_data_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             err_o
);
  localparam int PW    = $clog2(PROG_LOW_CYC + 1);
  localparam int CNT_W = (TMO_W > PW) ? TMO_W : PW;

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             last_seen;
  logic             rdy_s, done_s, pace_open;
  logic             data_slot, need_src, sending, fire, accept, phase_end;
  logic [7:0]       nxt_byte;

  fcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tgt_busy_ni), .q_o(rdy_s));
  fcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tgt_done_i), .q_o(done_s));
  fcs_pacer #(.GAP_CYC(GAP_CYC)) u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .open_o(pace_open));

  assign data_slot = (st == ST_FRAME) && (idx != '0) && (idx <= IDX_W'(DATA_N));
  assign need_src  = data_slot && !last_seen;
  assign sending   = (st == ST_HEAD) || (st == ST_FRAME) || (st == ST_TAIL);
  assign fire      = sending && pace_open && (!need_src || src_valid_i);
  assign accept    = fire && need_src;
  assign src_ready_o = need_src && pace_open;

  always_comb begin
    case (st)
      ST_HEAD:  phase_end = (idx == IDX_W'(HEAD_N - 1));
      ST_FRAME: phase_end = (idx == IDX_W'(FRAME_N - 1));
      default:  phase_end = (idx == IDX_W'(TAIL_N - 1));
    endcase
  end

  fcs_byte_sel u_sel (
    .st_i(st), .idx_i(idx), .use_src_i(need_src), .data_slot_i(data_slot),
    .src_data_i(src_data_i), .byte_o(nxt_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; idx <= '0; cnt <= '0; last_seen <= 1'b0;
      wr_o <= 1'b0; wr_data_o <= 8'h00; ok_o <= 1'b0; err_o <= 1'b0;
    end else begin
      wr_o <= fire;
      if (fire) wr_data_o <= nxt_byte;
      if (accept && src_last_i) last_seen <= 1'b1;
      case (st)
        ST_IDLE: if (start_i) begin
          st <= ST_CLEAR; cnt <= '0; idx <= '0; last_seen <= 1'b0;
          ok_o <= 1'b0; err_o <= 1'b0;
        end
        ST_CLEAR: begin
          if (cnt == CNT_W'(PROG_LOW_CYC - 1)) begin st <= ST_WAIT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_WAIT: begin
          if (rdy_s)                          st <= ST_HEAD;
          else if (cnt == CNT_W'(timeout_i)) begin st <= ST_IDLE; err_o <= 1'b1; end
          else                                cnt <= cnt + 1'b1;
        end
        ST_HEAD, ST_FRAME, ST_TAIL: if (fire) begin
          if (phase_end) begin
            idx <= '0;
            st  <= (st == ST_TAIL) ? ST_EVAL : ST_CHECK;
          end else idx <= idx + 1'b1;
        end
        ST_CHECK: st <= (rdy_s && !done_s && !last_seen) ? ST_FRAME : ST_TAIL;
        ST_EVAL: begin
          st    <= ST_IDLE;
          ok_o  <= last_seen && done_s;
          err_o <= !(last_seen && done_s);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tgt_reset_no = (st != ST_CLEAR);
  assign busy_o       = (st != ST_IDLE);

  // assertions
  p_quiet_in_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_reset_no |-> (!wr_o && busy_o));
  p_flag_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && err_o));
  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(err_o)));
  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && !src_valid_i) |=> !wr_o);
  p_ready_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> busy_o);
  if (GAP_CYC > 0) begin : g_gap_chk
    p_strobe_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_o |=> !wr_o);
  end
endmodule

// File: tb/fpga_cfg_sender_bench.sv
module fpga_cfg_sender_bench;
  localparam int PROG = 8;
  localparam int GAP  = 2;
  localparam int TW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [TW-1:0] timeout_i = 16'd200;
  logic [7:0] src_data_i = 8'h00;
  logic src_valid_i = 1'b0, src_last_i = 1'b0;
  logic src_ready_o, tgt_reset_no, wr_o, busy_o, ok_o, err_o;
  logic [7:0] wr_data_o;
  logic tgt_busy_ni = 1'b1;
  logic tgt_done_i = 1'b0;

  always #2 clk = ~clk;

  fpga_cfg_sender #(.PROG_LOW_CYC(PROG), .GAP_CYC(GAP), .TMO_W(TW), .SYNC_STAGES(2))
  u_fpga_cfg_sender (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .timeout_i(timeout_i),
    .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_last_i(src_last_i),
    .src_ready_o(src_ready_o), .tgt_reset_no(tgt_reset_no), .tgt_busy_ni(tgt_busy_ni),
    .tgt_done_i(tgt_done_i), .wr_o(wr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .ok_o(ok_o), .err_o(err_o));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] src_mem [256];
  logic [7:0] cap [256];
  logic [7:0] exp_b [256];
  int src_pos = 0, src_n = 0;
  bit stall_en = 0, never_ready = 0;
  int ready_delay = 20, rdy_cnt = 0;
  int drop_at = 1000, done_at = 1000;
  int ncap = 0, early_wr = 0, gap_bad = 0, last_wr = -100;
  bit ready_seen = 0;
  int low_run = 0, last_low = 0, clear_pulses = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // target model
  always @(posedge clk) begin
    if (!tgt_reset_no) begin
      tgt_busy_ni <= 1'b0; rdy_cnt <= 0; tgt_done_i <= 1'b0;
    end else begin
      if (ncap >= drop_at) tgt_busy_ni <= 1'b0;
      else if (!never_ready && rdy_cnt >= ready_delay) tgt_busy_ni <= 1'b1;
      rdy_cnt <= rdy_cnt + 1;
      if (ncap >= done_at) tgt_done_i <= 1'b1;
    end
  end

  // monitor
  always @(posedge clk) begin
    if (!tgt_reset_no) ready_seen <= 1'b0;
    else if (tgt_busy_ni) ready_seen <= 1'b1;
    if (wr_o) begin
      if (ncap < 256) cap[ncap] <= wr_data_o;
      ncap <= ncap + 1;
      if (!ready_seen) early_wr <= early_wr + 1;
      if (cyc - last_wr < GAP + 1) gap_bad <= gap_bad + 1;
      last_wr <= cyc;
    end
    if (!tgt_reset_no) low_run <= low_run + 1;
    else if (low_run != 0) begin
      last_low <= low_run; low_run <= 0; clear_pulses <= clear_pulses + 1;
    end
  end

  // source model
  always @(negedge clk) begin
    src_valid_i <= (src_pos < src_n) && !(stall_en && (cyc % 5 < 2));
    src_data_i  <= src_mem[src_pos % 256];
    src_last_i  <= (src_pos == src_n - 1);
  end
  always @(posedge clk) if (src_valid_i && src_ready_o) src_pos <= src_pos + 1;

  task automatic begin_run(input int n, input bit stall, input int dropat,
                           input int doneat, input bit nev, input int tmo);
    @(negedge clk);
    for (int i = 0; i < 256; i++) src_mem[i] = 8'((i * 37 + 11) ^ n);
    src_n = n; src_pos = 0; stall_en = stall; drop_at = dropat; done_at = doneat;
    never_ready = nev; timeout_i = TW'(tmo); ncap = 0; early_wr = 0; gap_bad = 0;
    last_wr = -100; clear_pulses = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int build_exp(input int n, input int nfr);
    int e = 0;
    exp_b[0] = 8'hFF; exp_b[1] = 8'hFF; exp_b[2] = 8'hFF; exp_b[3] = 8'h4F;
    exp_b[4] = 8'h80; exp_b[5] = 8'hAF; exp_b[6] = 8'h9B; exp_b[7] = 8'h4B;
    e = 8;
    for (int f = 0; f < nfr; f++) begin
      exp_b[e++] = 8'h4F;
      for (int k = 0; k < 21; k++) exp_b[e++] = (f * 21 + k < n) ? src_mem[f * 21 + k] : 8'hFF;
      exp_b[e++] = 8'h4B; exp_b[e++] = 8'hFF; exp_b[e++] = 8'h4B;
      exp_b[e++] = 8'hFF; exp_b[e++] = 8'hFF; exp_b[e++] = 8'hFF;
    end
    for (int t = 0; t < 4; t++) exp_b[e++] = 8'hFF;
    return e;
  endfunction

  task automatic check_stream(input int n, input int nfr, input string req);
    int en = build_exp(n, nfr);
    int bad = -1;
    chk(ncap == en, {req, " write count"}, ncap, en);
    for (int i = 0; i < en && i < ncap; i++) if (bad < 0 && cap[i] != exp_b[i]) bad = i;
    if (bad >= 0) chk(1'b0, {req, " byte value"}, int'(cap[bad]), int'(exp_b[bad]));
    else          chk(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    chk(tgt_reset_no && !wr_o && !src_ready_o && !busy_o && !ok_o && !err_o,
        "R1 reset state", {26'd0, tgt_reset_no, wr_o, src_ready_o, busy_o, ok_o, err_o}, 32);
  endtask

  task automatic t_normal();
    begin_run(42, 0, 1000, 8 + 56 + 2, 0, 200);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    wait_end();
    chk(last_low == PROG, "R2 clear width", last_low, PROG);
    chk(early_wr == 0, "R3 no write before ready", early_wr, 0);
    check_stream(42, 2, "R4 R5 R8 two frames");
    chk(gap_bad == 0, "R6 strobe spacing", gap_bad, 0);
    chk(ok_o && !err_o, "R9 success flags", {ok_o, err_o}, 2);
  endtask

  task automatic t_stall_pad();
    begin_run(30, 1, 1000, 8 + 56 + 2, 0, 200);
    wait_end();
    check_stream(30, 2, "R10 R11 stalls and pad");
    chk(src_pos == 30, "R11 no extra source reads", src_pos, 30);
    chk(ok_o && !err_o, "R10 stalled load succeeds", {ok_o, err_o}, 2);
    chk(gap_bad == 0, "R6 spacing with stalls", gap_bad, 0);
  endtask

  task automatic t_drop();
    begin_run(63, 0, 8 + 15, 1000, 0, 200);
    wait_end();
    check_stream(63, 1, "R7 ready drop stops framing");
    chk(err_o && !ok_o, "R9 error on incomplete data", {ok_o, err_o}, 1);
    chk(!busy_o, "R9 busy falls", busy_o, 0);
  endtask

  task automatic t_done_early();
    begin_run(63, 0, 1000, 8 + 10, 0, 200);
    wait_end();
    check_stream(63, 1, "R7 early done stops framing");
    chk(err_o && !ok_o, "R7 early done is error", {ok_o, err_o}, 1);
  endtask

  task automatic t_no_done();
    begin_run(21, 0, 1000, 1000, 0, 200);
    wait_end();
    check_stream(21, 1, "R8 single frame tail");
    chk(err_o && !ok_o, "R9 done low gives error", {ok_o, err_o}, 1);
  endtask

  task automatic t_timeout();
    begin_run(21, 0, 1000, 1000, 1, 20);
    chk(err_o == 1'b0, "R2 error cleared on start", err_o, 0);
    wait_end();
    chk(err_o && !ok_o, "R3 timeout error", {ok_o, err_o}, 1);
    chk(ncap == 0, "R3 no writes on timeout", ncap, 0);
    never_ready = 0;
  endtask

  task automatic t_restart_ignored();
    begin_run(21, 0, 1000, 8 + 28 + 2, 0, 200);
    while (ncap < 12) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end();
    chk(clear_pulses == 1, "R12 start ignored while busy", clear_pulses, 1);
    check_stream(21, 1, "R12 stream unchanged");
    chk(ok_o && !err_o, "R12 load still succeeds", {ok_o, err_o}, 2);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_stall_pad();
    t_drop();
    t_done_early();
    t_no_done();
    t_timeout();
    t_restart_ignored();
    finish_up();
  end
endmodule